// File: doc/BRIEF.md
# Emulated EEPROM Program/Erase Sequencer

This block sits behind a serial-bus command decoder and carries out byte-program and page-erase requests on a small on-chip array that emulates non-volatile storage. The decoder hands over a request as an address and a data byte. On the same cycle it gets one of three answers: accepted, refused (the decoder then sends NACK), or hold (the decoder stretches the bus clock and offers the same request again on a later cycle). Software sets the behaviour through an 8-bit control register. That register holds a one-shot write-protect bit, an erase-mode bit, a clock-extend bit and a flag that allows a read after address setup through a repeated start. The decoder reads the last of these on a dedicated pin.

A programmed byte can only lose ones. It takes the AND of its old contents and the new data. An erase restores a whole page to FFh. Each operation occupies the sequencer for a parameterised number of clock cycles that models the cell programming time, and `busy` is high for that time. A power-on reset fills the array with FFh and clears the whole control register, the write-protect bit included. Nothing else clears the write-protect bit.

Top module: `nvs_seq_top`

## Requirements
- R1: After power-on reset (`por_n` low) every array byte reads FFh, `ctl_rdata` is 00h, `rd_after_setup` is 0 and `busy` is 0.
- R2: A cycle with `ctl_we` high loads bit 7 (clock extend), bit 2 (erase mode) and bit 0 (read-after-setup) from `ctl_wdata`. `ctl_rdata` returns them in the same positions, with bits 6:4 and 1 reading 0. `rd_after_setup` equals bit 0.
- R3: Control bit 3 (write protect) is set by writing a 1. Writing 0 leaves it set, and only power-on reset clears it.
- R4: While write protect is set, every request gets `req_nack` and leaves the array unchanged, whatever the erase-mode bit is.
- R5: An accepted request with erase mode 0 replaces the byte at `req_addr` with old AND `req_data`. It never sets a bit.
- R6: An accepted request with erase mode 1 sets to FFh every byte whose address has the same page index (address shifted right by log2(PAGE)) as `req_addr`. `req_data` is ignored and other pages are untouched.
- R7: `busy` rises on the edge that accepts a request. It stays high for exactly PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase. The new contents are readable once `busy` has fallen.
- R8: A request that arrives while busy with clock extend set gets `req_stretch` for every cycle it is held. It is neither accepted nor refused and does not change the array.
- R9: A request that arrives while busy with clock extend clear gets `req_nack` and is dropped. It is never executed later.
- R10: For each cycle with `req_valid` high, exactly one of `req_accept`, `req_nack` and `req_stretch` is high. With `req_valid` low all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| rd_after_setup | output | 1 | Read after address setup allowed (control bit 0) |
| req_valid | input | 1 | Program/erase request present |
| req_addr | input | AW | Byte address of the request |
| req_data | input | 8 | Data byte of the request |
| req_accept | output | 1 | Request taken this cycle |
| req_nack | output | 1 | Request refused, decoder answers NACK |
| req_stretch | output | 1 | Request held, decoder stretches the clock |
| busy | output | 1 | Program or erase in progress |
| rd_addr | input | AW | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The bench programs an erased byte and then programs the same byte again with data that overlaps it only in part. A result other than the AND shows that the design overwrites instead of clearing bits. An erase is issued with a non-FFh data byte on an address in the middle of a page that holds programmed data. The bench then reads both ends of that page and a byte in the page next to it, which tells a whole-page erase apart from a single-byte one or one that spills into the next page. Requests made during busy are tried once with clock extend on and once with it off, which separates the hold answer from the refuse-and-drop answer. Write-protect tests follow a protect-then-clear control write, so a protect bit that software could clear would show.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    // Control register bit positions (software visible)
    localparam int CTL_RD_SETUP_BIT = 0;
    localparam int CTL_ERASE_BIT    = 2;
    localparam int CTL_WP_BIT       = 3;
    localparam int CTL_CLK_EXT_BIT  = 7;

    typedef struct packed {
        logic clk_ext;
        logic wp;
        logic erase_mode;
        logic rd_setup;
    } ctl_t;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_e;

endpackage

// File: rtl/nvs_ctrl_reg.sv
module nvs_ctrl_reg
    import nvs_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output ctl_t       ctl,
    output logic [7:0] rdata
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (we) begin
            ctl_d.clk_ext    = wdata[CTL_CLK_EXT_BIT];
            ctl_d.erase_mode = wdata[CTL_ERASE_BIT];
            ctl_d.rd_setup   = wdata[CTL_RD_SETUP_BIT];
            // protect bit is one-shot: OR in, never cleared by software
            ctl_d.wp         = ctl_q.wp | wdata[CTL_WP_BIT];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rdata                   = '0;
        rdata[CTL_CLK_EXT_BIT]  = ctl_q.clk_ext;
        rdata[CTL_WP_BIT]       = ctl_q.wp;
        rdata[CTL_ERASE_BIT]    = ctl_q.erase_mode;
        rdata[CTL_RD_SETUP_BIT] = ctl_q.rd_setup;
    end

    assign ctl = ctl_q;

    // R3
    wp_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        ctl_q.wp |=> ctl_q.wp);

endmodule

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
    parameter int PROG_CYCLES  = 12500,
    parameter int ERASE_CYCLES = 25000
) (
    input  logic clk,
    input  logic por_n,
    input  logic start,
    input  logic is_erase,
    output logic busy,
    output logic done
);

    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    assign done = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = is_erase ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
        end else if (done) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

    // R7
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        start |=> busy);

    // R7
    done_clears_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        done |=> !busy);

    // R7
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        busy |-> !start);

endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int DEPTH = 128,
    parameter int PAGE  = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          commit,
    input  logic          is_erase,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    localparam int PW = $clog2(PAGE);

    logic [DEPTH-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (commit) begin
            if (is_erase) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if ((AW'(i) >> PW) == (addr >> PW)) mem_d[i] = 8'hFF;
                end
            end else begin
                mem_d[addr] = mem_q[addr] & data;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) mem_q <= {DEPTH{8'hFF}};
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];

    // R4
    array_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !commit |=> $stable(mem_q));

    // R5
    prog_only_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        (commit && !is_erase) |=> ((mem_q[addr] & ~$past(mem_q[addr])) == 8'h00));

    // R6
    erase_fills_chk: assert property (@(posedge clk) disable iff (!por_n)
        (commit && is_erase) |=> (mem_q[addr] == 8'hFF));

endmodule

// File: rtl/nvs_seq_top.sv
module nvs_seq_top
    import nvs_pkg::*;
#(
    parameter int DEPTH        = 128,
    parameter int PAGE         = 32,
    parameter int PROG_CYCLES  = 12500,
    parameter int ERASE_CYCLES = 25000,
    parameter int AW           = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_wdata,
    output logic [7:0]    ctl_rdata,
    output logic          rd_after_setup,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          req_accept,
    output logic          req_nack,
    output logic          req_stretch,
    output logic          busy,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    typedef struct packed {
        op_e           kind;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } op_t;

    ctl_t ctl;
    logic tmr_busy, tmr_done;
    op_t  op_d, op_q;

    nvs_ctrl_reg u_ctl (
        .clk   (clk),
        .por_n (por_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl),
        .rdata (ctl_rdata)
    );

    // Request arbitration: protect wins, then busy handling, else take it
    always_comb begin
        req_accept  = 1'b0;
        req_nack    = 1'b0;
        req_stretch = 1'b0;
        if (req_valid) begin
            if (ctl.wp)              req_nack    = 1'b1;
            else if (!tmr_busy)      req_accept  = 1'b1;
            else if (ctl.clk_ext)    req_stretch = 1'b1;
            else                     req_nack    = 1'b1;
        end
    end

    always_comb begin
        op_d = op_q;
        if (req_accept) begin
            op_d.kind = ctl.erase_mode ? OP_ERASE : OP_PROG;
            op_d.addr = req_addr;
            op_d.data = req_data;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) op_q <= '0;
        else        op_q <= op_d;
    end

    nvs_busy_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_tmr (
        .clk      (clk),
        .por_n    (por_n),
        .start    (req_accept),
        .is_erase (ctl.erase_mode),
        .busy     (tmr_busy),
        .done     (tmr_done)
    );

    nvs_array #(
        .DEPTH (DEPTH),
        .PAGE  (PAGE),
        .AW    (AW)
    ) u_arr (
        .clk      (clk),
        .por_n    (por_n),
        .commit   (tmr_done),
        .is_erase (op_q.kind == OP_ERASE),
        .addr     (op_q.addr),
        .data     (op_q.data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    assign busy           = tmr_busy;
    assign rd_after_setup = ctl.rd_setup;

    // R10
    one_answer_chk: assert property (@(posedge clk) disable iff (!por_n)
        req_valid |-> $onehot({req_accept, req_nack, req_stretch}));

    // R10
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        !req_valid |-> !(req_accept || req_nack || req_stretch));

    // R4
    protect_refuses_chk: assert property (@(posedge clk) disable iff (!por_n)
        (req_valid && ctl_rdata[CTL_WP_BIT]) |-> req_nack);

    // R8
    stretch_holds_op_chk: assert property (@(posedge clk) disable iff (!por_n)
        req_stretch |=> $stable(op_q));

endmodule

// File: tb/tb_nvs_seq_top.sv
module tb_nvs_seq_top;

    localparam int DEPTH = 128;
    localparam int PAGE  = 32;
    localparam int PC    = 20;
    localparam int EC    = 40;
    localparam int AW    = 7;

    // expected answer codes
    localparam int ACC = 0, NAK = 1, STR = 2;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic [7:0]    ctl_rdata;
    logic          rd_after_setup;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_accept, req_nack, req_stretch, busy;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    always #10 clk = ~clk;   // 50 MHz

    nvs_seq_top #(
        .DEPTH(DEPTH), .PAGE(PAGE), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
    ) dut (
        .clk(clk), .por_n(por_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .rd_after_setup(rd_after_setup),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_accept(req_accept), .req_nack(req_nack), .req_stretch(req_stretch),
        .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] model [DEPTH];

    typedef struct {
        logic [AW-1:0] a;
        logic [7:0]    v;
        string         req;
    } item_t;
    item_t sb [$];

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard push of the model value at an address
    task automatic expect_byte(int a, string req);
        item_t it;
        it.a = AW'(a); it.v = model[a]; it.req = req;
        sb.push_back(it);
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // monitor: reads array through rd port when idle
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0 && !busy) begin
                item_t it;
                it = sb.pop_front();
                rd_addr = it.a;
                #1;
                chk(rd_data == it.v, it.req, rd_data, it.v);
            end
        end
    end

    task automatic por();
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        @(negedge clk);
    endtask

    task automatic ctl_write(logic [7:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    // one-cycle request; waits for completion when wait_done is set
    task automatic req(int a, logic [7:0] d, int exp, bit erase, bit wait_done, string tag);
        int code, cnt;
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a); req_data = d;
        #1;
        code = req_accept ? ACC : (req_nack ? NAK : (req_stretch ? STR : 3));
        chk(code == exp && $countones({req_accept, req_nack, req_stretch}) == 1,
            tag, code, exp);
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (code == ACC) begin
            if (erase) begin
                for (int i = 0; i < DEPTH; i++)
                    if ((i / PAGE) == (a / PAGE)) model[i] = 8'hFF;
            end else begin
                model[a] = model[a] & d;
            end
            if (wait_done) begin
                cnt = 0;
                @(negedge clk);
                while (busy) begin cnt++; @(negedge clk); end
                // R7: busy length
                chk(cnt == (erase ? EC : PC), "R7", cnt, erase ? EC : PC);
            end
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        por();
        // R1: reset state
        chk(busy == 1'b0, "R1", busy, 0);
        chk(ctl_rdata == 8'h00, "R1", ctl_rdata, 0);
        chk(rd_after_setup == 1'b0, "R1", rd_after_setup, 0);
        expect_byte(0, "R1"); expect_byte(31, "R1"); expect_byte(127, "R1");
        drain();

        // R10: no request, no answer
        #1;
        chk({req_accept, req_nack, req_stretch} == 3'b000, "R10",
            {req_accept, req_nack, req_stretch}, 0);

        // R2: control bits readback
        ctl_write(8'hF5);
        #1;
        chk(ctl_rdata == 8'h85, "R2", ctl_rdata, 8'h85);
        chk(rd_after_setup == 1'b1, "R2", rd_after_setup, 1);
        ctl_write(8'h00);
        #1;
        chk(ctl_rdata == 8'h00, "R2", ctl_rdata, 8'h00);

        // R5: program erased byte, then AND with partially overlapping data
        req(5, 8'hA5, ACC, 0, 1, "R5");
        expect_byte(5, "R5"); drain();
        req(5, 8'h3C, ACC, 0, 1, "R5");
        expect_byte(5, "R5"); drain();      // A5 & 3C = 24
        req(40, 8'h0F, ACC, 0, 1, "R5");
        req(63, 8'h00, ACC, 0, 1, "R5");
        req(32, 8'h5A, ACC, 0, 1, "R5");
        expect_byte(40, "R5"); drain();

        // R9: busy with clock extend clear -> refused and dropped
        req(6, 8'h00, ACC, 0, 0, "R9");
        req(7, 8'h00, NAK, 0, 0, "R9");
        wait_idle();
        expect_byte(6, "R9"); expect_byte(7, "R9"); drain();

        // R8: busy with clock extend set -> held for each cycle offered
        ctl_write(8'h80);
        req(8, 8'h11, ACC, 0, 0, "R8");
        for (int k = 0; k < 3; k++) req(9, 8'h00, STR, 0, 0, "R8");
        wait_idle();
        expect_byte(8, "R8"); expect_byte(9, "R8"); drain();

        // R6: erase mid-page with non-FF data
        ctl_write(8'h84);
        req(37, 8'h00, ACC, 1, 1, "R6");
        expect_byte(32, "R6"); expect_byte(40, "R6"); expect_byte(63, "R6");
        expect_byte(5, "R6"); expect_byte(8, "R6");
        drain();

        // R3/R4: protect, try to clear, then requests refused
        ctl_write(8'h00);
        req(70, 8'h12, ACC, 0, 1, "R5");
        ctl_write(8'h08);
        #1;
        chk(ctl_rdata == 8'h08, "R3", ctl_rdata, 8'h08);
        ctl_write(8'h00);
        #1;
        chk(ctl_rdata == 8'h08, "R3", ctl_rdata, 8'h08);
        req(5, 8'h00, NAK, 0, 1, "R4");
        ctl_write(8'h04);
        req(70, 8'h00, NAK, 1, 1, "R4");
        #1;
        chk(busy == 1'b0, "R4", busy, 0);
        expect_byte(5, "R4"); expect_byte(70, "R4"); drain();

        // R1/R3: power-on reset clears protect and array
        por();
        chk(ctl_rdata == 8'h00, "R3", ctl_rdata, 8'h00);
        expect_byte(5, "R1"); expect_byte(70, "R1"); drain();
        req(70, 8'hC3, ACC, 0, 1, "R3");
        expect_byte(70, "R3"); drain();

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule